// File: doc/BRIEF.md
# Message-Out Parser and Synchronous Transfer Negotiator

This block sits behind the target side of a parallel SCSI bus. It records the message bytes an initiator sends during a message-out phase that starts straight after selection. When the initiator drops ATN, the surrounding controller pulses a scan request. The block then walks the recorded bytes, one entry per clock, and picks the next bus step. That step is bus free (after an abort or a device reset), a message-in reply (a reject, or a synchronous negotiation answer), or on to the command phase.

The block also owns the negotiated transfer period and REQ/ACK offset. A device reset message zeroes the offset. An accepted negotiation loads both values, with the offset limited to a parameter (16 by default). The bus handshake is not part of this block: it only sees a byte strobe and returns a reply buffer, its length and an action code with a one-cycle done pulse.

Top module: `msgout_negotiator`

## Requirements
- R1: A pulse on `sel_entry` empties the byte store and arms recording. Bytes offered on `byte_vld` while recording is not armed are not stored, so a later scan does not see them.
- R2: The store index wraps modulo DEPTH (256). After exactly 256 stored bytes the stored count is zero.
- R3: A stored byte 0x06 stops the scan and returns action 2 (bus free).
- R4: A stored byte 0x0C stops the scan, sets `sync_offset` to 0 and returns action 2 (bus free).
- R5: Bytes 0x80 to 0xFF, and any other code not named here, cause no action; the scan moves on to the next entry.
- R6: A byte 0x01 stops the scan with action 1 (message in), `reply_len` 1 and reply byte 0x07 when `sync_en` is 0 or the entry two places after it is not 0x01.
- R7: Otherwise a 0x01 loads `sync_period` from the entry three places after it, and loads `sync_offset` from the entry four places after it limited to 16.
- R8: An accepted negotiation returns action 1, `reply_len` 5 and reply bytes 0x01, 0x03, 0x01, period, offset. Byte k is placed at `reply_data[8k+7:8k]`.
- R9: One entry is examined per clock. Suppose the edge that samples `scan_go` is edge 0, and i is the index of the deciding entry (or the stored count when none decides). Then `done` is high for exactly one cycle after edge i+1, and `action`, `reply_len` and `reply_data` hold from then on.
- R10: When no entry decides, the scan returns action 0 (command phase) and disarms recording.
- R11: Entries at or beyond the stored count read as 0x00. An extended message cut short therefore gets a reject.
- R12: After reset `sync_period` is 50, `sync_offset` is 0, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_entry | input | 1 | Message-out entered straight from selection; clears store and arms recording |
| byte_vld | input | 1 | Message byte strobe |
| byte_data | input | 8 | Message byte |
| scan_go | input | 1 | ATN released: start the scan (ignored while busy) |
| sync_en | input | 1 | Synchronous transfer allowed |
| done | output | 1 | One-cycle pulse: decision ready |
| action | output | 2 | 0 command, 1 message in, 2 bus free |
| reply_data | output | 40 | Reply bytes, byte k at bits 8k+7:8k |
| reply_len | output | 3 | Reply byte count (0, 1 or 5) |
| sync_period | output | 8 | Negotiated period factor |
| sync_offset | output | 8 | Negotiated REQ/ACK offset |
| busy | output | 1 | Scan in progress |

## Verification
Directed cases each isolate one decision. These are an empty store, a lone abort and device reset, rejects caused by a disabled `sync_en`, a wrong extended code and a message cut short, and negotiations with offsets below, at and above the limit. Filler identify bytes placed before a decisive byte show the per-entry latency. The 256- and 257-byte bursts tell a wrapping index from a saturating one. Random sequences mix identify bytes, unknown codes, aborts, resets and well-formed or broken extended messages under random `sync_en`, so the first-match priority and the register updates are compared with a bench model.

// File: rtl/msgneg_pkg.sv
package msgneg_pkg;
  localparam logic [7:0] MC_EXT      = 8'h01;
  localparam logic [7:0] MC_ABORT    = 8'h06;
  localparam logic [7:0] MC_REJECT   = 8'h07;
  localparam logic [7:0] MC_DEVRST   = 8'h0C;
  localparam logic [7:0] EXT_LEN_SYN = 8'h03;
  localparam logic [7:0] EXT_CODE_SYN = 8'h01;

  typedef enum logic [1:0] {
    ACT_CMD   = 2'd0,
    ACT_MSGIN = 2'd1,
    ACT_FREE  = 2'd2
  } act_e;

  // limit a requested offset
  function automatic logic [7:0] clamp_off(input logic [7:0] req, input logic [7:0] lim);
    return (req > lim) ? lim : req;
  endfunction

  // five-byte negotiation answer, byte 0 in the low bits
  function automatic logic [39:0] sync_reply(input logic [7:0] per, input logic [7:0] off);
    return {off, per, EXT_CODE_SYN, EXT_LEN_SYN, MC_EXT};
  endfunction

  function automatic logic [39:0] reject_reply();
    return {32'h0, MC_REJECT};
  endfunction
endpackage

// File: rtl/msg_store.sv
module msg_store #(
  parameter int DEPTH = 256,
  parameter int NTAP  = 5,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [7:0]           wr_data,
  input  logic                 flag_clr,
  input  logic [AW-1:0]        base,
  output logic [AW-1:0]        fill,
  output logic [NTAP-1:0][7:0] taps
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] cnt;
  logic          armed;

  // R1 clear-and-arm, R2 wrapping index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      cnt   <= '0;
      armed <= 1'b1;
    end else begin
      if (wr_en && armed) begin
        mem[cnt] <= wr_data;
        cnt      <= cnt + 1'b1;
      end
      if (flag_clr) armed <= 1'b0;
    end
  end

  assign fill = armed ? cnt : '0;

  // R11: read taps past the stored count give zero
  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    logic [AW:0] pos;
    assign pos     = {1'b0, base} + (AW+1)'(k);
    assign taps[k] = (pos < {1'b0, fill}) ? mem[pos[AW-1:0]] : 8'h00;
  end
endmodule

// File: rtl/msg_scan.sv
module msg_scan
  import msgneg_pkg::*;
#(
  parameter int AW      = 8,
  parameter int NTAP    = 5,
  parameter int OFF_MAX = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 sync_en,
  input  logic [AW-1:0]        fill,
  input  logic [NTAP-1:0][7:0] taps,
  output logic [AW-1:0]        base,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           action,
  output logic [39:0]          reply,
  output logic [2:0]           rlen,
  output logic                 ld_sync,
  output logic [7:0]           new_per,
  output logic [7:0]           new_off,
  output logic                 clr_off,
  output logic                 flag_clr
);
  logic at_end, hit_abort, hit_rst, hit_ext, ext_ok, finish;

  assign at_end    = busy && (base == fill);
  assign hit_abort = busy && !at_end && (taps[0] == MC_ABORT);   // R3
  assign hit_rst   = busy && !at_end && (taps[0] == MC_DEVRST);  // R4
  assign hit_ext   = busy && !at_end && (taps[0] == MC_EXT);     // R6 R7
  assign ext_ok    = sync_en && (taps[2] == EXT_CODE_SYN);
  assign finish    = at_end || hit_abort || hit_rst || hit_ext;

  assign ld_sync  = hit_ext && ext_ok;
  assign new_per  = taps[3];
  assign new_off  = clamp_off(taps[4], 8'(OFF_MAX));
  assign clr_off  = hit_rst;
  assign flag_clr = at_end || hit_abort || hit_rst;              // R10

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      base   <= '0;
      done   <= 1'b0;
      action <= ACT_CMD;
      reply  <= '0;
      rlen   <= '0;
    end else begin
      done <= busy && finish;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          base <= '0;
        end
      end else if (finish) begin
        busy <= 1'b0;
        if (at_end) begin
          action <= ACT_CMD;
          reply  <= '0;
          rlen   <= 3'd0;
        end else if (hit_abort || hit_rst) begin
          action <= ACT_FREE;
          reply  <= '0;
          rlen   <= 3'd0;
        end else if (ext_ok) begin
          action <= ACT_MSGIN;
          reply  <= sync_reply(new_per, new_off);                // R8
          rlen   <= 3'd5;
        end else begin
          action <= ACT_MSGIN;
          reply  <= reject_reply();
          rlen   <= 3'd1;
        end
      end else begin
        base <= base + 1'b1;                                     // R5 R9
      end
    end
  end
endmodule

// File: rtl/sync_regs.sv
module sync_regs #(
  parameter int PER_RST = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] per_in,
  input  logic [7:0] off_in,
  input  logic       clr_off,
  output logic [7:0] period,
  output logic [7:0] offset
);
  // R12 reset values, R4 clear, R7 load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= 8'(PER_RST);
      offset <= 8'h00;
    end else if (clr_off) begin
      offset <= 8'h00;
    end else if (ld) begin
      period <= per_in;
      offset <= off_in;
    end
  end
endmodule

// File: rtl/msgout_negotiator.sv
module msgout_negotiator #(
  parameter int DEPTH   = 256,
  parameter int OFF_MAX = 16,
  parameter int PER_RST = 50,
  localparam int AW     = $clog2(DEPTH),
  localparam int NTAP   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_entry,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic        scan_go,
  input  logic        sync_en,
  output logic        done,
  output logic [1:0]  action,
  output logic [39:0] reply_data,
  output logic [2:0]  reply_len,
  output logic [7:0]  sync_period,
  output logic [7:0]  sync_offset,
  output logic        busy
);
  logic [AW-1:0]        base, fill;
  logic [NTAP-1:0][7:0] taps;
  logic                 ld_sync, clr_off, flag_clr;
  logic [7:0]           new_per, new_off;

  msg_store #(.DEPTH(DEPTH), .NTAP(NTAP)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(sel_entry),
    .wr_en(byte_vld && !busy), .wr_data(byte_data),
    .flag_clr(flag_clr), .base(base), .fill(fill), .taps(taps)
  );

  msg_scan #(.AW(AW), .NTAP(NTAP), .OFF_MAX(OFF_MAX)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(scan_go), .sync_en(sync_en),
    .fill(fill), .taps(taps), .base(base), .busy(busy), .done(done),
    .action(action), .reply(reply_data), .rlen(reply_len),
    .ld_sync(ld_sync), .new_per(new_per), .new_off(new_off),
    .clr_off(clr_off), .flag_clr(flag_clr)
  );

  sync_regs #(.PER_RST(PER_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld(ld_sync), .per_in(new_per),
    .off_in(new_off), .clr_off(clr_off),
    .period(sync_period), .offset(sync_offset)
  );
endmodule

// File: rtl/msgneg_chk.sv
module msgneg_chk #(
  parameter int AW      = 8,
  parameter int OFF_MAX = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_entry,
  input logic          done,
  input logic          busy,
  input logic [1:0]    action,
  input logic [39:0]   reply_data,
  input logic [2:0]    reply_len,
  input logic [7:0]    sync_period,
  input logic [7:0]    sync_offset,
  input logic [AW-1:0] fill,
  input logic          clr_off
);
  assert_entry_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_entry |=> fill == '0);

  assert_devrst_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_off |=> sync_offset == 8'h00);

  assert_reject_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && reply_len == 3'd1 |-> reply_data[7:0] == 8'h07 && action == 2'd1);

  assert_offset_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_offset <= 8'(OFF_MAX));

  assert_reply_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && reply_len == 3'd5 |-> reply_data[31:24] == sync_period
      && reply_data[39:32] == sync_offset && reply_data[23:0] == 24'h010301);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_cmd_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && action == 2'd0 |-> reply_len == 3'd0);
endmodule

bind msgout_negotiator msgneg_chk #(.AW(AW), .OFF_MAX(OFF_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_entry(sel_entry), .done(done), .busy(busy),
  .action(action), .reply_data(reply_data), .reply_len(reply_len),
  .sync_period(sync_period), .sync_offset(sync_offset),
  .fill(fill), .clr_off(clr_off)
);

// File: tb/sim_msgout_negotiator.sv
module sim_msgout_negotiator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_entry = 1'b0, byte_vld = 1'b0, scan_go = 1'b0, sync_en = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        done, busy;
  logic [1:0]  action;
  logic [39:0] reply_data;
  logic [2:0]  reply_len;
  logic [7:0]  sync_period, sync_offset;

  int n_run = 0, n_fail = 0, cyc = 0;

  // bench model state
  logic [7:0] m_buf [256];
  int         m_cnt = 0;
  bit         m_arm = 0;
  int         m_per = 50, m_off = 0;

  always #4 clk = ~clk;

  msgout_negotiator u0 (
    .clk(clk), .rst_n(rst_n), .sel_entry(sel_entry), .byte_vld(byte_vld),
    .byte_data(byte_data), .scan_go(scan_go), .sync_en(sync_en), .done(done),
    .action(action), .reply_data(reply_data), .reply_len(reply_len),
    .sync_period(sync_period), .sync_offset(sync_offset), .busy(busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rd(input int i);
    return (m_arm && i < m_cnt) ? int'(m_buf[i]) : 0;
  endfunction

  task automatic enter();
    @(negedge clk) sel_entry = 1'b1;
    @(negedge clk) sel_entry = 1'b0;
    m_arm = 1;
    m_cnt = 0;
    for (int i = 0; i < 256; i++) m_buf[i] = 8'h00;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk) begin byte_vld = 1'b1; byte_data = b; end
    @(negedge clk) byte_vld = 1'b0;
    if (m_arm) begin
      m_buf[m_cnt] = b;
      m_cnt = (m_cnt + 1) % 256;
    end
  endtask

  // model a scan and compare against the block
  task automatic scan_chk(input string req);
    int eff, i, e_act, e_len, e_lat, lat;
    logic [7:0] r [5];
    bit hit;
    eff = m_arm ? m_cnt : 0;
    hit = 0; e_act = 0; e_len = 0;
    for (int j = 0; j < 5; j++) r[j] = 8'h00;
    i = 0;
    while (i < eff && !hit) begin
      if (rd(i) == 8'h06) begin
        hit = 1; e_act = 2;
      end else if (rd(i) == 8'h0C) begin
        hit = 1; e_act = 2; m_off = 0;
      end else if (rd(i) == 8'h01) begin
        hit = 1; e_act = 1;
        if (!sync_en || rd(i + 2) != 8'h01) begin
          e_len = 1; r[0] = 8'h07;
        end else begin
          m_per = rd(i + 3);
          m_off = (rd(i + 4) > 16) ? 16 : rd(i + 4);
          e_len = 5; r[0] = 8'h01; r[1] = 8'h03; r[2] = 8'h01;
          r[3] = 8'(m_per); r[4] = 8'(m_off);
        end
      end else begin
        i++;
      end
    end
    e_lat = i + 1;
    if (e_act != 1) m_arm = 0;

    @(negedge clk) scan_go = 1'b1;
    @(negedge clk) scan_go = 1'b0;
    lat = 0;
    while (!done && lat < 600) begin
      @(negedge clk);
      lat++;
    end
    chk(req, "latency (R9)", lat, e_lat);
    chk(req, "action", int'(action), e_act);
    chk(req, "reply_len", int'(reply_len), e_len);
    for (int j = 0; j < e_len; j++)
      chk(req, $sformatf("reply byte %0d (R8)", j), int'(reply_data[8*j +: 8]), int'(r[j]));
    chk(req, "period", int'(sync_period), m_per);
    chk(req, "offset", int'(sync_offset), m_off);
    @(negedge clk);
    chk("R9", "done one cycle", int'(done), 0);
  endtask

  task automatic ext(input logic [7:0] code, input logic [7:0] per, input logic [7:0] off);
    put(8'h01); put(8'h03); put(code); put(per); put(off);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R9 watchdog: got %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "period after reset", int'(sync_period), 50);
    chk("R12", "offset after reset", int'(sync_offset), 0);
    chk("R12", "busy after reset", int'(busy), 0);
    chk("R12", "done after reset", int'(done), 0);

    // R10: empty store goes to command
    enter(); scan_chk("R10");
    // R1: bytes after disarm are not stored
    put(8'h06); scan_chk("R1");
    // R3: abort after identify fillers
    enter(); put(8'h80); put(8'hC3); put(8'h06); put(8'h0C); scan_chk("R3");
    // R6: sync disabled
    sync_en = 1'b0; enter(); put(8'h81); ext(8'h01, 8'd25, 8'd8); scan_chk("R6");
    // R7: accepted below limit
    sync_en = 1'b1; enter(); put(8'h80); ext(8'h01, 8'd25, 8'd8); scan_chk("R7");
    // R4: device reset clears offset
    enter(); put(8'h02); put(8'h0C); scan_chk("R4");
    // R7: offset above and at limit
    enter(); ext(8'h01, 8'd12, 8'd40); scan_chk("R7");
    enter(); ext(8'h01, 8'd90, 8'd16); scan_chk("R7");
    // R6: wrong extended code
    enter(); ext(8'h02, 8'd30, 8'd4); scan_chk("R6");
    // R11: extended cut short
    enter(); put(8'h01); put(8'h03); scan_chk("R11");
    // R5: identify and unknown codes only
    enter(); put(8'hFF); put(8'h03); put(8'h80); scan_chk("R5");
    // R2: 256 bytes wrap to empty; 257th lands at entry 0
    enter(); for (int k = 0; k < 256; k++) put(8'h06); scan_chk("R2");
    enter(); for (int k = 0; k < 256; k++) put(8'h80); put(8'h06); scan_chk("R2");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int n;
      sync_en = 1'($urandom % 2);
      enter();
      n = int'($urandom % 7);
      for (int k = 0; k < n; k++) begin
        int c;
        c = int'($urandom % 10);
        if (c < 5)       put(8'h80 | 8'($urandom));
        else if (c == 5) put(8'h06);
        else if (c == 6) put(8'h0C);
        else if (c == 7) put(8'h02 + 8'($urandom % 4));
        else ext(($urandom % 3 == 0) ? 8'h02 : 8'h01, 8'($urandom), 8'($urandom % 40));
      end
      scan_chk("R5");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule